// File: doc/BRIEF.md
# Low-Power Test Pattern Generator with Intermediate Vectors

This block produces pseudo-random test vectors for a logic block under built-in self-test. It keeps the number of output bits that toggle from one vector to the next low. An 8-stage shift register with XOR feedback is split into two halves that advance on different cycles. A holding flip-flop carries the last stage of the first half into the second half. Between two full register steps the block places three intermediate vectors. In two of them, each bit whose next value differs from its present value is replaced by a shared random bit. The result is that any one output update touches at most half of the bus.

After a synchronous seed load, the generator runs from a single test-enable input. Each cycle with the enable high advances one phase of a four-phase cycle: full step of the first half, masked second half, step of the second half, masked first half. The bus is registered, so it changes on the same edge that moves the register. With the enable low, everything holds.

Top module: `lowpower_pattern_gen`

## Requirements
- R1: While reset is asserted, the output bus is all zeros, and the first enabled phase after reset is the first-half step.
- R2: A cycle with seed_load high copies the seed to the bus on the next edge, loads the holding flip-flop with seed bit 4, and restarts the phase cycle at the first-half step.
- R3: Stage k maps to bus bit 8-k (stage 1 is bit 7). In the first-half step, stages 1..4 shift toward stage 4, stage 1 takes stage 8 XOR stage 1, and the holding flop takes the old stage 4. The bus shows all eight stages, and bits 3..0 are unchanged.
- R4: In the second-half mask phase, no stage changes and bus bits 7..4 are unchanged. Each of bus bits 3..0 shows its stage when that stage's next value equals its present value, and otherwise shows stage 8.
- R5: In the second-half step, stages 5..8 shift toward stage 8, and stage 5 takes the holding flop. Bus bits 3..0 show the new stages, and bits 7..4 are unchanged.
- R6: In the first-half mask phase, no stage changes and bus bits 3..0 are unchanged. Bus bits 7..4 apply the R4 masking rule to stages 1..4, where the next value of stage 1 is stage 8 XOR stage 1.
- R7: With test_en and seed_load both low, the bus and the phase hold.
- R8: From seed 8'b0100_1011, five enabled cycles give 8'b1010_1011, 8'b1010_1111, 8'b1010_0101, 8'b1111_0101 and 8'b0101_0101.
- R9: When seed_load and test_en are high together, the load wins and no phase is taken.
- R10: Any single enabled update changes at most four bus bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_en | input | 1 | Advance one phase this cycle |
| seed_load | input | 1 | Synchronous seed load, restarts the phase cycle |
| seed | input | 8 | Seed value, bit 7 is stage 1 |
| lp_out | output | 8 | Registered low-power pattern bus |

## Verification
The hardest case to reach is a mask phase in which particular stages agree or disagree with their next values while stage 8 has a chosen value. From the ports, the only way to set up the register is to load a seed and step through the phases. The bench therefore sweeps all 256 seeds and runs each one for three full phase cycles against an independent stage-level model. This covers every combination of agreeing and disagreeing bits in both halves. Loads arriving in the middle of a cycle, and loads arriving together with the enable, show that the phase restart is observable at the bus.

// File: rtl/lowpower_pattern_gen.sv
module lowpower_pattern_gen #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         test_en,
  input  logic         seed_load,
  input  logic [W-1:0] seed,
  output logic [W-1:0] lp_out
);
  localparam int H = W / 2;

  typedef enum logic [1:0] {PH_T, PH_A, PH_B, PH_C} phase_t;

  phase_t       phase;
  logic [W-1:0] q;
  logic         hold;
  logic         fb;
  logic [H-1:0] q_hi, q_lo, d_hi, d_lo, diff_hi, diff_lo, inj_hi, inj_lo;

  assign q_hi    = q[W-1:H];
  assign q_lo    = q[H-1:0];
  assign fb      = q[0] ^ q[W-1];
  assign d_hi    = {fb, q_hi[H-1:1]};
  assign d_lo    = {hold, q_lo[H-1:1]};
  assign diff_hi = d_hi ^ q_hi;
  assign diff_lo = d_lo ^ q_lo;
  assign inj_hi  = (q_hi & ~diff_hi) | ({H{q[0]}} & diff_hi);
  assign inj_lo  = (q_lo & ~diff_lo) | ({H{q[0]}} & diff_lo);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q      <= '0;
      hold   <= 1'b0;
      phase  <= PH_T;
      lp_out <= '0;
    end else if (seed_load) begin
      q      <= seed;
      hold   <= seed[H];
      phase  <= PH_T;
      lp_out <= seed;
    end else if (test_en) begin
      phase <= phase_t'(phase + 2'd1);
      case (phase)
        PH_T: begin
          q[W-1:H] <= d_hi;
          hold     <= q[H];
          lp_out   <= {d_hi, q_lo};
        end
        PH_A: lp_out <= {q_hi, inj_lo};
        PH_B: begin
          q[H-1:0] <= d_lo;
          lp_out   <= {lp_out[W-1:H], d_lo};
        end
        default: lp_out <= {inj_hi, lp_out[H-1:0]};
      endcase
    end
  end
endmodule

// File: rtl/lowpower_pattern_gen_chk.sv
module lowpower_pattern_gen_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         en,
  input logic         load,
  input logic [W-1:0] seed,
  input logic [1:0]   phase,
  input logic [W-1:0] lp_out
);
  localparam int H = W / 2;

  a_r2_load_copies_seed: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (lp_out == $past(seed)) && (phase == 2'd0));

  a_r7_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !load) |=> $stable(lp_out) && $stable(phase));

  a_r3_low_half_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !load && phase == 2'd0) |=> $stable(lp_out[H-1:0]));

  a_r4_high_half_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !load && phase == 2'd1) |=> $stable(lp_out[W-1:H]));

  a_r5_high_half_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !load && phase == 2'd2) |=> $stable(lp_out[W-1:H]));

  a_r6_low_half_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !load && phase == 2'd3) |=> $stable(lp_out[H-1:0]));

  a_r10_half_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !load) |=> ($countones(lp_out ^ $past(lp_out)) <= H));

  a_r9_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (en && load) |=> phase == 2'd0);
endmodule

bind lowpower_pattern_gen lowpower_pattern_gen_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(test_en), .load(seed_load),
  .seed(seed), .phase(phase), .lp_out(lp_out)
);

// File: tb/lowpower_pattern_gen_bench.sv
module lowpower_pattern_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       test_en = 1'b0;
  logic       seed_load = 1'b0;
  logic [7:0] seed = '0;
  logic [7:0] lp_out;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [1:8] ms, mout;
  logic       mh;
  int         mph;

  always #5 clk = ~clk;

  lowpower_pattern_gen u_lowpower_pattern_gen (
    .clk(clk), .rst_n(rst_n), .test_en(test_en), .seed_load(seed_load),
    .seed(seed), .lp_out(lp_out)
  );

  task automatic chk(input string tag, input logic [7:0] exp);
    checks++;
    if (lp_out !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", tag, lp_out, exp);
    end
  endtask

  task automatic model_load(input logic [7:0] s);
    ms = s; mout = s; mh = s[4]; mph = 0;
  endtask

  task automatic model_step();
    logic nx, f;
    case (mph)
      0: begin
        f = ms[8] ^ ms[1];
        mh = ms[4];
        for (int k = 4; k >= 2; k--) ms[k] = ms[k-1];
        ms[1] = f;
        mout = ms;
      end
      1: begin
        mout[1:4] = ms[1:4];
        for (int k = 5; k <= 8; k++) begin
          nx = (k == 5) ? mh : ms[k-1];
          mout[k] = (nx == ms[k]) ? ms[k] : ms[8];
        end
      end
      2: begin
        for (int k = 8; k >= 6; k--) ms[k] = ms[k-1];
        ms[5] = mh;
        mout[5:8] = ms[5:8];
      end
      default: begin
        for (int k = 1; k <= 4; k++) begin
          nx = (k == 1) ? (ms[8] ^ ms[1]) : ms[k-1];
          mout[k] = (nx == ms[k]) ? ms[k] : ms[8];
        end
      end
    endcase
    mph = (mph + 1) % 4;
  endtask

  task automatic do_load(input logic [7:0] s, input logic with_en);
    @(negedge clk);
    seed = s; seed_load = 1'b1; test_en = with_en;
    @(posedge clk); #1;
    seed_load = 1'b0; test_en = 1'b0;
    model_load(s);
  endtask

  task automatic do_step();
    @(negedge clk);
    test_en = 1'b1;
    @(posedge clk); #1;
    test_en = 1'b0;
    model_step();
  endtask

  function automatic string ph_tag(input int p);
    case (p)
      1: return "R3 first-half step";
      2: return "R4 second-half mask";
      3: return "R5 second-half step";
      default: return "R6 first-half mask";
    endcase
  endfunction

  initial begin
    logic [7:0] prev;
    repeat (3) @(posedge clk);
    #1 chk("R1 reset value", 8'h00);
    @(negedge clk) rst_n = 1'b1;

    do_load(8'b0100_1011, 1'b0);
    chk("R2 seed on bus", 8'b0100_1011);
    do_step(); chk("R8 T1", 8'b1010_1011);
    do_step(); chk("R8 Ta", 8'b1010_1111);
    do_step(); chk("R8 Tb", 8'b1010_0101);
    do_step(); chk("R8 Tc", 8'b1111_0101);
    do_step(); chk("R8 T2", 8'b0101_0101);

    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      @(posedge clk); #1;
      chk("R7 idle hold", 8'b0101_0101);
    end
    do_step(); chk("R7 phase kept while idle", mout);

    do_load(8'b0100_1011, 1'b1);
    chk("R9 load beats enable", 8'b0100_1011);
    do_step(); chk("R9 restart at first-half step", 8'b1010_1011);

    do_step();
    do_load(8'b1100_0110, 1'b0);
    chk("R2 mid-cycle load", 8'b1100_0110);
    do_step(); chk("R2 restart phase", mout);

    for (int s = 0; s < 256; s++) begin
      do_load(s[7:0], 1'b0);
      chk("R2 sweep load", mout);
      for (int n = 0; n < 12; n++) begin
        prev = lp_out;
        do_step();
        chk(ph_tag(mph), mout);
        checks++;
        if ($countones(lp_out ^ prev) > 4) begin
          fails++;
          $display("FAIL R10: got %0d toggles expected <= 4", $countones(lp_out ^ prev));
        end
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule